// File: doc/BRIEF.md
# Core-Voltage Window Monitor with Over-Voltage Latch

This block watches a digitised sample of a regulator's output voltage against a window derived from the programmed reference value. Each threshold is a fixed-point multiple of the reference. The sample is compared by cross-multiplying, so no division is needed and the result is exact.

An under-voltage detector with hysteresis and a soft-start-done input together decide the power-good output. The under-voltage detector does not latch and has no other effect.

An over-voltage trip sets a latch that only the power-on reset clears. While the latch is set, the block overrides the PWM outputs as a hysteretic shunt. It clamps them low while the voltage is at or above the trip point. It releases them to three-state once the voltage drops below a slightly lower release point. It keeps the last choice while the voltage is between the two points.

All outputs are registered and follow the inputs by one clock edge.

Top module: `core_vmon`

## Requirements
- R1: While `por` is high, `pgood` is 0, `uv_flag` is 1, `ov_latched` is 0 and `pwm_ovr` is 2'b00. This holds whatever the sample value is.
- R2: A threshold with factor K counts as reached when `vsample*256 >= vref*K`. A sample exactly on a threshold therefore counts as reached. The default factors are 236 (under-voltage rising), 230 (under-voltage falling), 294 (over-voltage trip) and 289 (over-voltage release).
- R3: While `uv_flag` is 0, a sample below the falling threshold (factor 230) sets `uv_flag` at the next edge. A sample exactly on that threshold does not set it.
- R4: While `uv_flag` is 1, it clears only when the sample reaches the rising threshold (factor 236). Samples between the falling and rising thresholds leave it unchanged.
- R5: A sample at or above the trip threshold sets `ov_latched`. The flag then stays 1 for every sample value until `por` is asserted.
- R6: While the latch is set, `pwm_ovr` is 2'b01 (clamp low) after a sample at or above the trip threshold. It is 2'b10 (three-state) after a sample below the release threshold (factor 289). Samples between the two thresholds keep the previous code.
- R7: While `ov_latched` is 0, `pwm_ovr` is 2'b00 (no override). Under-voltage does not change this.
- R8: `pgood` is 1 one edge after a cycle in which `ss_done` is 1, the under-voltage state is clear and the latch is clear. Otherwise `pgood` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, active high, asynchronous |
| vsample | input | W (12) | Sampled output-voltage word |
| vref | input | W (12) | Programmed reference value |
| ss_done | input | 1 | Soft start has completed |
| pgood | output | 1 | Power-good |
| uv_flag | output | 1 | Under-voltage state |
| ov_latched | output | 1 | Over-voltage latch state |
| pwm_ovr | output | 2 | PWM override: 00 none, 01 clamp low, 10 three-state |

## Verification
The hardest situation to reach is the dwell band of the latched shunt. To check it, the sample must first cross the trip point and then land on values between the release and trip points, from both directions. Only then does it show that the override code is held rather than recomputed. The stimulus uses a reference of 256 so that every threshold falls on an exact integer and the equality cases are unambiguous. It also uses a reference of 1000 so that rounding sits between adjacent codes. The sequence then drives a normal and a deep under-voltage sample into a latched block to show that the latch is sticky, and ends with a power-on reset to show that only the reset clears it.

// File: rtl/vmon_pkg.sv
package vmon_pkg;

    typedef enum logic [1:0] {
        OVR_NONE = 2'b00,
        OVR_LOW  = 2'b01,
        OVR_HIZ  = 2'b10
    } pwm_ovr_e;

    typedef struct packed {
        logic latched;
        logic clamp;
    } ov_state_t;

    localparam int unsigned NCMP    = 4;
    localparam int unsigned IDX_UVR = 0;
    localparam int unsigned IDX_UVF = 1;
    localparam int unsigned IDX_OVT = 2;
    localparam int unsigned IDX_OVR = 3;

endpackage

// File: rtl/vmon_cmp.sv
module vmon_cmp #(
    parameter int unsigned W    = 12,
    parameter int unsigned FRAC = 8,
    parameter int unsigned K    = 256
) (
    input  logic [W-1:0] sample_i,
    input  logic [W-1:0] ref_i,
    output logic         reached_o
);
    localparam int unsigned PW = W + FRAC + 2;

    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;

    always_comb begin
        lhs       = {2'b00, sample_i, {FRAC{1'b0}}};
        rhs       = PW'(ref_i) * PW'(K);
        reached_o = (lhs >= rhs);
    end
endmodule

// File: rtl/vmon_uv.sv
module vmon_uv (
    input  logic clk,
    input  logic por,
    input  logic reach_rise_i,
    input  logic below_fall_i,
    output logic uv_d_o,
    output logic uv_q_o
);
    logic uv_d, uv_q;

    always_comb begin
        uv_d = uv_q;
        if (uv_q && reach_rise_i)
            uv_d = 1'b0;
        else if (!uv_q && below_fall_i)
            uv_d = 1'b1;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) uv_q <= 1'b1;
        else     uv_q <= uv_d;
    end

    assign uv_d_o = uv_d;
    assign uv_q_o = uv_q;

    p_uv_set_r3: assert property (@(posedge clk) disable iff (por)
        (!uv_q && below_fall_i) |=> uv_q);
    p_uv_clear_r4: assert property (@(posedge clk) disable iff (por)
        (uv_q && !reach_rise_i) |=> uv_q);
endmodule

// File: rtl/vmon_ov.sv
module vmon_ov
    import vmon_pkg::*;
(
    input  logic     clk,
    input  logic     por,
    input  logic     trip_i,
    input  logic     below_rel_i,
    output logic     latched_d_o,
    output logic     latched_q_o,
    output pwm_ovr_e ovr_o
);
    ov_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (trip_i) begin
            st_d.latched = 1'b1;
            st_d.clamp   = 1'b1;
        end else if (st_q.latched && below_rel_i) begin
            st_d.clamp   = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) st_q <= '0;
        else     st_q <= st_d;
    end

    always_comb begin
        if (!st_q.latched)   ovr_o = OVR_NONE;
        else if (st_q.clamp) ovr_o = OVR_LOW;
        else                 ovr_o = OVR_HIZ;
    end

    assign latched_d_o = st_d.latched;
    assign latched_q_o = st_q.latched;

    p_latch_sticky_r5: assert property (@(posedge clk) disable iff (por)
        st_q.latched |=> st_q.latched);
    p_clamp_on_trip_r6: assert property (@(posedge clk) disable iff (por)
        trip_i |=> (ovr_o == OVR_LOW));
    p_release_hiz_r6: assert property (@(posedge clk) disable iff (por)
        (st_q.latched && !trip_i && below_rel_i) |=> (ovr_o == OVR_HIZ));
endmodule

// File: rtl/core_vmon.sv
module core_vmon
    import vmon_pkg::*;
#(
    parameter int unsigned W         = 12,
    parameter int unsigned FRAC      = 8,
    parameter int unsigned K_UV_RISE = 236,
    parameter int unsigned K_UV_FALL = 230,
    parameter int unsigned K_OV_TRIP = 294,
    parameter int unsigned K_OV_REL  = 289
) (
    input  logic         clk,
    input  logic         por,
    input  logic [W-1:0] vsample,
    input  logic [W-1:0] vref,
    input  logic         ss_done,
    output logic         pgood,
    output logic         uv_flag,
    output logic         ov_latched,
    output logic [1:0]   pwm_ovr
);
    function automatic int unsigned k_of(input int unsigned idx);
        case (idx)
            IDX_UVR: return K_UV_RISE;
            IDX_UVF: return K_UV_FALL;
            IDX_OVT: return K_OV_TRIP;
            default: return K_OV_REL;
        endcase
    endfunction

    logic [NCMP-1:0] reached;

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        vmon_cmp #(.W(W), .FRAC(FRAC), .K(k_of(g))) u_cmp (
            .sample_i  (vsample),
            .ref_i     (vref),
            .reached_o (reached[g])
        );
    end

    logic     uv_d, uv_q, ov_d, ov_q;
    pwm_ovr_e ovr;

    vmon_uv u_uv (
        .clk          (clk),
        .por          (por),
        .reach_rise_i (reached[IDX_UVR]),
        .below_fall_i (!reached[IDX_UVF]),
        .uv_d_o       (uv_d),
        .uv_q_o       (uv_q)
    );

    vmon_ov u_ov (
        .clk         (clk),
        .por         (por),
        .trip_i      (reached[IDX_OVT]),
        .below_rel_i (!reached[IDX_OVR]),
        .latched_d_o (ov_d),
        .latched_q_o (ov_q),
        .ovr_o       (ovr)
    );

    logic pg_d, pg_q;

    always_comb begin
        pg_d = ss_done && !uv_d && !ov_d;
    end

    always_ff @(posedge clk or posedge por) begin
        if (por) pg_q <= 1'b0;
        else     pg_q <= pg_d;
    end

    assign pgood      = pg_q;
    assign uv_flag    = uv_q;
    assign ov_latched = ov_q;
    assign pwm_ovr    = ovr;

    p_pgood_needs_ss_r8: assert property (@(posedge clk) disable iff (por)
        pgood |-> $past(ss_done));
    p_latch_blocks_pg_r5: assert property (@(posedge clk) disable iff (por)
        ov_latched |-> !pgood);
    p_uv_blocks_pg_r8: assert property (@(posedge clk) disable iff (por)
        uv_flag |-> !pgood);
    p_no_ovr_idle_r7: assert property (@(posedge clk) disable iff (por)
        !ov_latched |-> (pwm_ovr == 2'b00));
endmodule

// File: tb/core_vmon_bench.sv
module core_vmon_bench;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         por = 1'b1;
    logic [W-1:0] vsample = '0;
    logic [W-1:0] vref = 12'd256;
    logic         ss_done = 1'b0;
    logic         pgood, uv_flag, ov_latched;
    logic [1:0]   pwm_ovr;

    core_vmon u_core_vmon (
        .clk(clk), .por(por), .vsample(vsample), .vref(vref), .ss_done(ss_done),
        .pgood(pgood), .uv_flag(uv_flag), .ov_latched(ov_latched), .pwm_ovr(pwm_ovr)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic       pg;
        logic       uv;
        logic       ov;
        logic [1:0] ovr;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 0;

    logic m_uv = 1'b1, m_ov = 1'b0, m_cl = 1'b0;

    task automatic step(input logic p, input int s, input int r, input logic ss, input string tag);
        exp_t e;
        longint ls;
        @(negedge clk);
        por = p; vsample = W'(s); vref = W'(r); ss_done = ss;
        ls = longint'(s) * 256;
        if (p) begin
            m_uv = 1'b1; m_ov = 1'b0; m_cl = 1'b0;
        end else begin
            if (m_uv && ls >= longint'(r) * 236) m_uv = 1'b0;
            else if (!m_uv && ls < longint'(r) * 230) m_uv = 1'b1;
            if (ls >= longint'(r) * 294) begin
                m_ov = 1'b1; m_cl = 1'b1;
            end else if (m_ov && ls < longint'(r) * 289) begin
                m_cl = 1'b0;
            end
        end
        e.pg  = !p && ss && !m_uv && !m_ov;
        e.uv  = m_uv;
        e.ov  = m_ov;
        e.ovr = !m_ov ? 2'b00 : (m_cl ? 2'b01 : 2'b10);
        e.tag = tag;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (pgood !== e.pg || uv_flag !== e.uv || ov_latched !== e.ov || pwm_ovr !== e.ovr) begin
                n_bad++;
                $display("FAIL %s: got pg=%b uv=%b ov=%b ovr=%b, expected pg=%b uv=%b ov=%b ovr=%b",
                         e.tag, pgood, uv_flag, ov_latched, pwm_ovr, e.pg, e.uv, e.ov, e.ovr);
            end
        end
    end

    initial begin
        step(1, 0,    256,  0, "R1 reset state");
        step(1, 1200, 256,  1, "R1 reset ignores sample");
        step(0, 240,  256,  0, "R8 no pgood before soft start");
        step(0, 240,  256,  1, "R8 pgood after soft start");
        step(0, 230,  256,  1, "R3 on falling threshold keeps uv clear");
        step(0, 229,  256,  1, "R3 below falling threshold sets uv");
        step(0, 235,  256,  1, "R4 between thresholds holds uv");
        step(0, 236,  256,  1, "R4 on rising threshold clears uv");
        step(0, 100,  256,  1, "R7 uv leaves override idle");
        step(0, 922,  1000, 1, "R2 rounding rising threshold");
        step(0, 1148, 1000, 1, "R2 just under trip");
        step(0, 1149, 1000, 1, "R5 trip sets latch and clamp");
        step(0, 1129, 1000, 1, "R6 band holds clamp");
        step(0, 1128, 1000, 1, "R6 below release goes three-state");
        step(0, 1140, 1000, 1, "R6 band holds three-state");
        step(0, 294,  256,  1, "R6 exact trip clamps again");
        step(0, 289,  256,  1, "R6 exact release keeps clamp");
        step(0, 288,  256,  1, "R6 below exact release three-state");
        step(0, 240,  256,  1, "R5 latch sticky at normal voltage");
        step(0, 100,  256,  1, "R5 latch sticky under deep uv");
        step(1, 240,  256,  1, "R5 only por clears latch");
        step(0, 250,  256,  1, "R8 pgood after por release");
        step(0, 250,  256,  0, "R8 pgood drops with ss_done");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule